// File: doc/BRIEF.md
# Pulsed Bandwidth-Capping Address Throttle

This block sits on the address channel of a memory bus that uses a valid/ready handshake. It shapes the traffic in two ways. A phase timer alternates between an open window and a shut window, and each window lasts a number of cycles taken from a configuration input. A word meter adds up the burst lengths of the requests admitted in the current pulse cycle, which is one open window followed by one shut window. When the total reaches a configured cap, the meter stops any further admission until the next open window begins.

The cap is applied per request, not per word. A request is admitted whenever the running total is still below the cap, even if its burst carries the total past the cap. This keeps bursts whole, and the price is a bounded overshoot in each pulse cycle. The block only gates the handshake: it holds no request and adds no latency. The configuration inputs are treated as static. Typical settings are an open window and a shut window of about 5100 cycles each, with a cap of about 625 words. The current phase and the word total are brought out to ports so that they can be observed.

Top module: `bw_pulse_throttle`

## Requirements
- R1: Counting from the first cycle after reset, `phase_open` is high for `cfg_on_len` cycles, where a value of 0 behaves as 1. It is then low for `cfg_off_len` cycles, and this sequence repeats.
- R2: While `phase_open` is low, `up_ready` and `dn_valid` are both low, whatever `up_valid` and `dn_ready` are.
- R3: `words_used` is 0 in the first cycle of every open window.
- R4: Each accepted handshake (`up_valid` and `up_ready` both high) adds `up_len` to `words_used` in the next cycle. The total saturates at all ones. Outside a window start, `words_used` holds its value in any cycle with no handshake.
- R5: With `cfg_cap` nonzero and `words_used` >= `cfg_cap`, `up_ready` and `dn_valid` stay low until the next open window.
- R6: A request is admitted while `words_used` < `cfg_cap`, even when `up_len` takes the total beyond the cap.
- R7: When `cfg_cap` is 0 there is no word limit, and only the phases gate traffic.
- R8: When `cfg_off_len` is 0, `phase_open` stays high. A new pulse cycle then starts every `cfg_on_len` cycles, and `words_used` is cleared at each such start.
- R9: While reset is asserted (synchronous, active low), the block is in the open phase with `words_used` at 0.
- R10: While admitting, `up_ready` equals `dn_ready`, `dn_valid` equals `up_valid`, and `dn_len` equals `up_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_on_len | input | CNT_W | Open window length in cycles (static) |
| cfg_off_len | input | CNT_W | Shut window length in cycles; 0 means never shut (static) |
| cfg_cap | input | WORD_W | Word cap per pulse cycle; 0 means unlimited (static) |
| up_valid | input | 1 | Request valid from the requester |
| up_ready | output | 1 | Request accepted toward the requester |
| up_len | input | LEN_W | Burst length of the request, in 64-bit words |
| dn_valid | output | 1 | Gated request valid toward the memory side |
| dn_ready | input | 1 | Ready from the memory side |
| dn_len | output | LEN_W | Burst length passed downstream |
| phase_open | output | 1 | High during the open window |
| words_used | output | WORD_W | Words admitted so far in the current pulse cycle |

## Verification
The throttle is exercised with five input patterns. Valid and ready held high show the exact point where the cap stops admission, and the overshoot that follows. Ready toggling each cycle shows that only completed handshakes are counted. Valid held low, and ready held low, each show that the total does not move without a handshake. A single oversized burst against a small cap tells per-request enforcement apart from per-word enforcement. Edge settings are also covered: a shut length of zero, an open length of zero, a cap of zero, and a long run that drives the total into saturation. Together these separate a phase fault from a metering fault.

// File: rtl/bwpt_pkg.sv
package bwpt_pkg;

    typedef enum logic {
        PH_OPEN = 1'b0,
        PH_SHUT = 1'b1
    } phase_e;

endpackage

// File: rtl/bwpt_phase_timer.sv
module bwpt_phase_timer
    import bwpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    output logic             open_o,
    output logic             wrap_o
);

    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } timer_st_t;

    timer_st_t st_d, st_q;

    logic [EXT_W-1:0] elapsed;
    logic [EXT_W-1:0] on_eff;
    logic             on_done;
    logic             off_done;

    always_comb begin
        elapsed  = {1'b0, st_q.cnt} + EXT_W'(1);
        on_eff   = (on_len == '0) ? EXT_W'(1) : {1'b0, on_len};
        on_done  = elapsed >= on_eff;
        off_done = elapsed >= {1'b0, off_len};
        st_d     = st_q;
        wrap_o   = 1'b0;
        st_d.cnt = st_q.cnt + CNT_W'(1);
        if (st_q.phase == PH_OPEN) begin
            if (on_done) begin
                st_d.cnt = '0;
                if (off_len == '0) begin
                    wrap_o = 1'b1;
                end else begin
                    st_d.phase = PH_SHUT;
                end
            end
        end else begin
            if (off_done) begin
                st_d.cnt   = '0;
                st_d.phase = PH_OPEN;
                wrap_o     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_OPEN;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = (st_q.phase == PH_OPEN);

endmodule

// File: rtl/bwpt_word_meter.sv
module bwpt_word_meter #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              fire,
    input  logic [LEN_W-1:0]  len,
    output logic [WORD_W-1:0] words_o
);

    localparam int SUM_W = WORD_W + 1;
    localparam int PAD_W = SUM_W - LEN_W;

    typedef struct packed {
        logic [WORD_W-1:0] words;
    } meter_st_t;

    meter_st_t st_d, st_q;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = {1'b0, st_q.words} + {{PAD_W{1'b0}}, len};
        st_d = st_q;
        if (wrap) begin
            st_d.words = '0;
        end else if (fire) begin
            st_d.words = sum[WORD_W] ? {WORD_W{1'b1}} : sum[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.words <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words_o = st_q.words;

endmodule

// File: rtl/bwpt_admit.sv
module bwpt_admit #(
    parameter int WORD_W = 16
) (
    input  logic              open_i,
    input  logic [WORD_W-1:0] words,
    input  logic [WORD_W-1:0] cap,
    input  logic              up_valid,
    input  logic              dn_ready,
    output logic              up_ready,
    output logic              dn_valid,
    output logic              fire
);

    logic cap_ok;
    logic allow;

    always_comb begin
        cap_ok   = (cap == '0) || (words < cap);
        allow    = open_i && cap_ok;
        up_ready = dn_ready && allow;
        dn_valid = up_valid && allow;
        fire     = up_valid && dn_ready && allow;
    end

endmodule

// File: rtl/bw_pulse_throttle.sv
module bw_pulse_throttle #(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 16,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_on_len,
    input  logic [CNT_W-1:0]  cfg_off_len,
    input  logic [WORD_W-1:0] cfg_cap,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [LEN_W-1:0]  up_len,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [LEN_W-1:0]  dn_len,
    output logic              phase_open,
    output logic [WORD_W-1:0] words_used
);

    logic pulse_wrap;
    logic hs_fire;

    bwpt_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_len  (cfg_on_len),
        .off_len (cfg_off_len),
        .open_o  (phase_open),
        .wrap_o  (pulse_wrap)
    );

    bwpt_word_meter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (pulse_wrap),
        .fire    (hs_fire),
        .len     (up_len),
        .words_o (words_used)
    );

    bwpt_admit #(.WORD_W(WORD_W)) i_admit (
        .open_i   (phase_open),
        .words    (words_used),
        .cap      (cfg_cap),
        .up_valid (up_valid),
        .dn_ready (dn_ready),
        .up_ready (up_ready),
        .dn_valid (dn_valid),
        .fire     (hs_fire)
    );

    assign dn_len = up_len;

endmodule

// File: rtl/bw_pulse_throttle_chk.sv
module bw_pulse_throttle_chk #(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 16,
    parameter int LEN_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cfg_off_len,
    input logic [WORD_W-1:0] cfg_cap,
    input logic              up_valid,
    input logic              up_ready,
    input logic [LEN_W-1:0]  up_len,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [LEN_W-1:0]  dn_len,
    input logic              phase_open,
    input logic [WORD_W-1:0] words_used,
    input logic              wrap
);

    localparam int SUM_W = WORD_W + 1;

    logic             hs;
    logic [SUM_W-1:0] sum;
    logic             capped;
    logic             admitting;

    assign hs        = up_valid && up_ready;
    assign sum       = {1'b0, words_used} + SUM_W'(up_len);
    assign capped    = (cfg_cap != '0) && (words_used >= cfg_cap);
    assign admitting = phase_open && !capped;

    a_r2_shut_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_open |-> (!up_ready && !dn_valid));

    a_r5_cap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        capped |-> (!up_ready && !dn_valid));

    a_r3_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (words_used == '0 && phase_open));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs && !wrap) |=> $stable(words_used));

    a_r4_add_len: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !wrap && !sum[WORD_W]) |=>
            (words_used == $past(sum[WORD_W-1:0])));

    a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        admitting |-> (up_ready == dn_ready && dn_valid == up_valid && dn_len == up_len));

    a_r8_never_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_off_len == '0 && phase_open) |=> phase_open);

endmodule

bind bw_pulse_throttle bw_pulse_throttle_chk #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_off_len (cfg_off_len),
    .cfg_cap     (cfg_cap),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_len      (up_len),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .dn_len      (dn_len),
    .phase_open  (phase_open),
    .words_used  (words_used),
    .wrap        (pulse_wrap)
);

// File: tb/test_bw_pulse_throttle.sv
module test_bw_pulse_throttle;

    localparam int CNT_W  = 16;
    localparam int WORD_W = 16;
    localparam int LEN_W  = 9;
    localparam int WMAX   = (1 << WORD_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CNT_W-1:0]  cfg_on_len;
    logic [CNT_W-1:0]  cfg_off_len;
    logic [WORD_W-1:0] cfg_cap;
    logic              up_valid;
    logic              up_ready;
    logic [LEN_W-1:0]  up_len;
    logic              dn_valid;
    logic              dn_ready;
    logic [LEN_W-1:0]  dn_len;
    logic              phase_open;
    logic [WORD_W-1:0] words_used;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_on, m_off, m_cap, m_pos, m_words;

    always #2 clk = ~clk;

    bw_pulse_throttle #(.CNT_W(CNT_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) i_bw_pulse_throttle (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_on_len  (cfg_on_len),
        .cfg_off_len (cfg_off_len),
        .cfg_cap     (cfg_cap),
        .up_valid    (up_valid),
        .up_ready    (up_ready),
        .up_len      (up_len),
        .dn_valid    (dn_valid),
        .dn_ready    (dn_ready),
        .dn_len      (dn_len),
        .phase_open  (phase_open),
        .words_used  (words_used)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic start(input int on, input int off, input int cap);
        cfg_on_len  = CNT_W'(on);
        cfg_off_len = CNT_W'(off);
        cfg_cap     = WORD_W'(cap);
        up_valid    = 1'b0;
        dn_ready    = 1'b0;
        up_len      = '0;
        rst_n       = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b1;
        m_on    = (on == 0) ? 1 : on;
        m_off   = off;
        m_cap   = cap;
        m_pos   = 0;
        m_words = 0;
    endtask

    // One cycle: drive, compare against the model, advance the model.
    task automatic step(input bit vld, input bit rdy, input int len);
        bit exp_open;
        bit allow;
        bit fire;
        up_valid = vld;
        dn_ready = rdy;
        up_len   = LEN_W'(len);
        #1;
        exp_open = (m_pos < m_on);
        allow    = exp_open && (m_cap == 0 || m_words < m_cap);
        check((m_off == 0) ? "R8 phase" : "R1 phase", int'(phase_open), int'(exp_open));
        if (!exp_open) begin
            check("R2 up_ready shut", int'(up_ready), 0);
            check("R2 dn_valid shut", int'(dn_valid), 0);
        end else if (!allow) begin
            check("R5 up_ready capped", int'(up_ready), 0);
            check("R5 dn_valid capped", int'(dn_valid), 0);
        end else begin
            check((m_cap == 0) ? "R7 up_ready" : "R10 up_ready", int'(up_ready), int'(rdy));
            check("R10 dn_valid", int'(dn_valid), int'(vld));
            check("R10 dn_len", int'(dn_len), len);
        end
        check((m_pos == 0) ? "R3 words at start" : "R4 words", int'(words_used), m_words);
        fire = vld && rdy && allow;
        if (m_pos == m_on + m_off - 1) begin
            m_pos   = 0;
            m_words = 0;
        end else begin
            m_pos++;
            if (fire) m_words = (m_words + len > WMAX) ? WMAX : m_words + len;
        end
        @(negedge clk);
    endtask

    // mode 0: valid+ready, 1: ready toggles, 2: valid low, 3: ready low
    task automatic run(input int n, input int mode, input int len);
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: step(1'b1, 1'b1, len);
                1: step(1'b1, i[0], len);
                2: step(1'b0, 1'b1, len);
                default: step(1'b1, 1'b0, len);
            endcase
        end
    endtask

    task automatic t_reset();
        start(6, 3, 10);
        rst_n = 1'b0;
        up_valid = 1'b1;
        dn_ready = 1'b1;
        up_len = LEN_W'(4);
        repeat (2) @(posedge clk);
        #1;
        check("R9 open in reset", int'(phase_open), 1);
        check("R9 words in reset", int'(words_used), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run(4, 0, 4);
    endtask

    task automatic t_phases();
        start(6, 3, 0);
        run(30, 0, 5);
        start(6, 3, 0);
        run(30, 1, 7);
    endtask

    task automatic t_cap_overshoot();
        start(30, 5, 10);
        run(3, 0, 4);
        #1;
        check("R6 overshoot total", int'(words_used), 12);
        check("R5 stalled after cap", int'(up_ready), 0);
        run(80, 0, 4);
    endtask

    task automatic t_big_burst();
        start(10, 4, 10);
        run(1, 0, 300);
        #1;
        check("R6 big burst admitted", int'(words_used), 300);
        run(30, 0, 300);
    endtask

    task automatic t_idle();
        start(8, 2, 5);
        run(12, 2, 3);
        run(12, 3, 3);
        run(10, 1, 2);
    endtask

    task automatic t_no_off();
        start(5, 0, 8);
        run(23, 0, 3);
    endtask

    task automatic t_on_zero();
        start(0, 2, 0);
        run(10, 0, 1);
    endtask

    task automatic t_saturate();
        start(400, 0, 0);
        run(270, 0, 255);
        #1;
        check("R4 saturated total", int'(words_used), WMAX);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_phases();
        t_cap_overshoot();
        t_big_burst();
        t_idle();
        t_no_off();
        t_on_zero();
        t_saturate();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule